// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects up to 32 interrupt inputs and reduces them to one active-low request line for a processor. Each input has its own mode register, which holds a 3-bit priority and a trigger type, and its own vector register. Software enables and disables inputs through write-one command registers and can read back the resulting mask.

To service an interrupt, software reads the vector register. The read returns the vector of the winning input and pushes that input's priority onto an internal nesting stack. While that level is open, only inputs of strictly higher priority can raise the request again. A write to the end-of-interrupt register closes the innermost level. When no input qualifies, the vector read returns a programmable spurious value and does not touch the stack.

The register bus is a single-cycle word bus. Reads are combinational from the current state. A write, or the side effect of a vector read, takes effect at the clock edge that ends the access.

Top module: `prio_irq_ctrl`

Word addresses: mode registers 0..31, vector registers 32..63, vector read 64, spurious vector 65, enable command 66, disable command 67, edge-clear command 68, mask read 69, end-of-interrupt 70.

## Requirements
- R1: After reset the mask reads 0, every mode and vector register reads 0, the spurious vector is 0 and `irq_n` is high.
- R2: A mode register holds the priority in bits [2:0] (0 lowest, 7 highest) and the trigger in bits [5:4]. The trigger codes are 00 high level, 01 rising edge, 10 low level and 11 falling edge. Both fields read back as written.
- R3: Each 1 bit written to the enable command sets that input's mask bit, and each 1 bit written to the disable command clears it. 0 bits leave the mask unchanged. The mask reads back at address 69, bit n for input n.
- R4: Only inputs 0, 29, 30 and 31 are external pins. On any other input, a mode write that selects trigger 10 or 11 leaves the trigger field unchanged, while the priority field is still written.
- R5: A level-triggered input is pending while its input is at the active level (1 for high, 0 for low). It stays pending after being acknowledged.
- R6: An edge-triggered input latches a pending flag on its selected edge. A vector read that acknowledges the input clears that flag.
- R7: Writing a 1 to bit n of the edge-clear command clears the latched pending flag of input n.
- R8: A vector read returns the vector of the enabled pending input with the highest priority. On a tie in priority, the lower input number wins.
- R9: When no input qualifies for the request line, a vector read returns the spurious vector and leaves the nesting stack unchanged.
- R10: `irq_n` is low only when an enabled pending input has a priority strictly above the priority on top of the stack, or when the stack is empty. An acknowledging read pushes the winning priority.
- R11: Each end-of-interrupt write pops one level, up to 8 levels. A write to an empty stack has no effect, so 8 writes always return the controller to idle.
- R12: `irq_n` responds at the first clock edge after a level input changes, and at the second clock edge after an active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_src | input | 32 | Interrupt inputs |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A level input that changes before a clock edge moves `irq_n` just after that edge. An edge input takes one more edge, because it passes through an edge-detect register and then a latch. The bench drives inputs on falling edges and samples `irq_n` on the falling edge one or two cycles later. It also checks one cycle early to show that the result is not yet visible. Register writes and acknowledging reads act at the single rising edge inside the access, so every read-back and `irq_n` check is taken on the falling edge that closes that access.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int DEPTH = 8,
  parameter logic [NSRC-1:0] EXT_SRC = 'hE000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_src,
  output logic            irq_n
);
  localparam int IW = $clog2(NSRC);
  localparam int SW = $clog2(DEPTH + 1);
  localparam int KW = $clog2(DEPTH);
  localparam logic [AW-1:0] A_VEC  = AW'(NSRC);
  localparam logic [AW-1:0] A_IVR  = AW'(2 * NSRC);
  localparam logic [AW-1:0] A_SPU  = AW'(2 * NSRC + 1);
  localparam logic [AW-1:0] A_EN   = AW'(2 * NSRC + 2);
  localparam logic [AW-1:0] A_DIS  = AW'(2 * NSRC + 3);
  localparam logic [AW-1:0] A_CLR  = AW'(2 * NSRC + 4);
  localparam logic [AW-1:0] A_MASK = AW'(2 * NSRC + 5);
  localparam logic [AW-1:0] A_EOI  = AW'(2 * NSRC + 6);

  logic [2:0]      prio_q [NSRC];
  logic [1:0]      trig_q [NSRC];
  logic [DW-1:0]   vec_q  [NSRC];
  logic [DW-1:0]   spu_q;
  logic [NSRC-1:0] mask_q, src_q, src_p, edg_q, pend, ev;
  logic [2:0]      stk [DEPTH];
  logic [SW-1:0]   sp;

  logic          found, qual, wr, rd_ivr, ack, eoi;
  logic [IW-1:0] best, idx;
  logic [2:0]    bpr, top;

  assign wr     = bus_sel & bus_wr;
  assign rd_ivr = bus_sel & ~bus_wr & (bus_addr == A_IVR);
  assign eoi    = wr & (bus_addr == A_EOI);
  assign idx    = bus_addr[IW-1:0];

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      pend[i] = trig_q[i][0] ? edg_q[i] : (src_q[i] ^ trig_q[i][1]);
      ev[i]   = trig_q[i][1] ? (src_p[i] & ~src_q[i]) : (src_q[i] & ~src_p[i]);
    end
  end

  always_comb begin
    found = 1'b0;
    best  = '0;
    bpr   = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i] && mask_q[i] && (!found || prio_q[i] > bpr)) begin
        found = 1'b1;
        best  = IW'(i);
        bpr   = prio_q[i];
      end
  end

  assign top   = (sp == '0) ? 3'd0 : stk[KW'(sp - SW'(1))];
  assign qual  = found && (sp == '0 || bpr > top);
  assign ack   = rd_ivr && qual && (sp != SW'(DEPTH));
  assign irq_n = ~qual;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_VEC) begin
      bus_rdata[2:0] = prio_q[idx];
      bus_rdata[5:4] = trig_q[idx];
    end else if (bus_addr < A_IVR) begin
      bus_rdata = vec_q[idx];
    end else begin
      case (bus_addr)
        A_IVR:   bus_rdata = qual ? vec_q[best] : spu_q;
        A_SPU:   bus_rdata = spu_q;
        A_MASK:  bus_rdata[NSRC-1:0] = mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= '0;
        trig_q[i] <= '0;
        vec_q[i]  <= '0;
      end
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
      spu_q  <= '0;
      mask_q <= '0;
      src_q  <= '0;
      src_p  <= '0;
      edg_q  <= '0;
      sp     <= '0;
    end else begin
      src_q  <= irq_src;
      src_p  <= src_q;
      mask_q <= (mask_q | ((wr && bus_addr == A_EN) ? bus_wdata[NSRC-1:0] : '0))
                & ~((wr && bus_addr == A_DIS) ? bus_wdata[NSRC-1:0] : '0);
      if (wr && bus_addr == A_SPU) spu_q <= bus_wdata;
      for (int i = 0; i < NSRC; i++) begin
        if (wr && bus_addr == AW'(i)) begin
          prio_q[i] <= bus_wdata[2:0];
          if (EXT_SRC[i] || !bus_wdata[5]) trig_q[i] <= bus_wdata[5:4];
        end
        if (wr && bus_addr == A_VEC + AW'(i)) vec_q[i] <= bus_wdata;
        if (!trig_q[i][0]) edg_q[i] <= 1'b0;
        else if (ev[i]) edg_q[i] <= 1'b1;
        else if ((ack && best == IW'(i)) || (wr && bus_addr == A_CLR && bus_wdata[i]))
          edg_q[i] <= 1'b0;
      end
      if (ack) begin
        stk[KW'(sp)] <= bpr;
        sp <= sp + SW'(1);
      end else if (eoi && sp != '0) begin
        sp <= sp - SW'(1);
      end
    end
  end

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_EN) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_DIS) |=> ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));
  assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ivr && irq_n) |=> $stable(sp));
  assert_ack_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ivr && !irq_n) |=> (sp == $past(sp) + SW'(1)));
  assert_eoi_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && sp != '0) |=> (sp == $past(sp) - SW'(1)));
  assert_depth_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SW'(DEPTH));

  for (genvar k = 1; k < DEPTH; k++) begin : g_ord
    assert_stack_rising_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sp > SW'(k)) |-> (stk[k] > stk[k-1]));
  end
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam logic [7:0] A_IVR = 8'd64, A_SPU = 8'd65, A_EN = 8'd66, A_DIS = 8'd67,
                         A_CLR = 8'd68, A_MASK = 8'd69, A_EOI = 8'd70;
  localparam logic [31:0] SPUR = 32'h0000_DEAD;

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, irq_src = '0;
  logic irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src), .irq_n(irq_n));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    rd_chk("R1 mask", A_MASK, 32'd0);
    rd_chk("R1 mode", 8'd4, 32'd0);
    rd_chk("R1 vector", 8'd36, 32'd0);
    rd_chk("R1 spurious", A_IVR, 32'd0);
  endtask

  task automatic t_config;
    wr(A_SPU, SPUR);
    for (int i = 0; i < 32; i++) wr(8'(32 + i), 32'h100 + i);
    rd_chk("R2 vector rb", 8'd45, 32'h10D);
    wr(8'd3, 32'h02);
    rd_chk("R2 mode high", 8'd3, 32'h02);
    wr(8'd5, 32'h15);
    rd_chk("R2 mode rising", 8'd5, 32'h15);
  endtask

  task automatic t_illegal;
    wr(8'd10, 32'h23);
    rd_chk("R4 internal low rejected", 8'd10, 32'h03);
    wr(8'd12, 32'h36);
    rd_chk("R4 internal falling rejected", 8'd12, 32'h06);
    wr(8'd30, 32'h36);
    rd_chk("R4 external falling", 8'd30, 32'h36);
  endtask

  task automatic t_mask;
    wr(A_EN, 32'h28);
    rd_chk("R3 enable", A_MASK, 32'h28);
    wr(A_EN, 32'h400);
    rd_chk("R3 enable keeps", A_MASK, 32'h428);
    wr(A_DIS, 32'h20);
    rd_chk("R3 disable", A_MASK, 32'h408);
    wr(A_DIS, 32'h0);
    rd_chk("R3 zero no effect", A_MASK, 32'h408);
    wr(A_DIS, 32'hFFFF_FFFF);
    rd_chk("R3 disable all", A_MASK, 32'h0);
  endtask

  task automatic t_level;
    wr(A_EN, 32'h8);
    @(negedge clk); irq_src[3] = 1'b1;
    #1 chk("R12 level not early", {31'd0, irq_n}, 32'd1);
    @(negedge clk);
    chk("R12 level one edge", {31'd0, irq_n}, 32'd0);
    rd_chk("R8 level vector", A_IVR, 32'h103);
    chk("R10 same level blocked", {31'd0, irq_n}, 32'd1);
    wr(A_EOI, 0);
    chk("R5 level stays pending", {31'd0, irq_n}, 32'd0);
    @(negedge clk); irq_src[3] = 1'b0;
    @(negedge clk);
    chk("R5 level released", {31'd0, irq_n}, 32'd1);
    rd_chk("R9 spurious", A_IVR, SPUR);
    wr(A_EOI, 0);
    chk("R11 eoi on empty", {31'd0, irq_n}, 32'd1);
    wr(A_DIS, 32'h8);
    @(negedge clk); irq_src[31] = 1'b1;
    wr(8'd31, 32'h21);
    wr(A_EN, 32'h8000_0000);
    chk("R5 low level inactive", {31'd0, irq_n}, 32'd1);
    @(negedge clk); irq_src[31] = 1'b0;
    @(negedge clk);
    chk("R5 low level active", {31'd0, irq_n}, 32'd0);
    rd_chk("R8 low vector", A_IVR, 32'h11F);
    wr(A_EOI, 0);
    @(negedge clk); irq_src[31] = 1'b1;
    wr(A_DIS, 32'h8000_0000);
  endtask

  task automatic t_edge;
    wr(A_EN, 32'h20);
    @(negedge clk); irq_src[5] = 1'b1;
    @(negedge clk);
    chk("R12 edge not after one", {31'd0, irq_n}, 32'd1);
    @(negedge clk);
    chk("R12 edge after two", {31'd0, irq_n}, 32'd0);
    rd_chk("R6 rising vector", A_IVR, 32'h105);
    wr(A_EOI, 0);
    chk("R6 ack clears latch", {31'd0, irq_n}, 32'd1);
    @(negedge clk); irq_src[5] = 1'b0;
    @(negedge clk); @(negedge clk); irq_src[5] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 relatched", {31'd0, irq_n}, 32'd0);
    wr(A_CLR, 32'h20);
    chk("R7 clear command", {31'd0, irq_n}, 32'd1);
    @(negedge clk); irq_src[5] = 1'b0;
    wr(A_DIS, 32'h20);
    @(negedge clk); irq_src[30] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(A_EN, 32'h4000_0000);
    chk("R6 no falling yet", {31'd0, irq_n}, 32'd1);
    @(negedge clk); irq_src[30] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 falling latched", {31'd0, irq_n}, 32'd0);
    rd_chk("R6 falling vector", A_IVR, 32'h11E);
    wr(A_EOI, 0);
    chk("R6 falling cleared", {31'd0, irq_n}, 32'd1);
    wr(A_DIS, 32'h4000_0000);
  endtask

  task automatic t_prio;
    wr(8'd7, 32'h04);
    wr(8'd9, 32'h04);
    wr(8'd12, 32'h06);
    @(negedge clk); irq_src[7] = 1'b1; irq_src[9] = 1'b1;
    wr(A_EN, 32'h280);
    chk("R10 empty stack asserts", {31'd0, irq_n}, 32'd0);
    rd_chk("R8 tie lower index", A_IVR, 32'h107);
    chk("R10 equal priority blocked", {31'd0, irq_n}, 32'd1);
    @(negedge clk); irq_src[12] = 1'b1;
    wr(A_EN, 32'h1000);
    chk("R10 higher preempts", {31'd0, irq_n}, 32'd0);
    rd_chk("R8 higher vector", A_IVR, 32'h10C);
    chk("R10 top level blocks", {31'd0, irq_n}, 32'd1);
    wr(A_EOI, 0);
    chk("R11 pop reopens", {31'd0, irq_n}, 32'd0);
    wr(A_EOI, 0);
    rd_chk("R8 highest wins", A_IVR, 32'h10C);
    wr(A_EOI, 0);
    @(negedge clk); irq_src = '0;
    wr(A_DIS, 32'hFFFF_FFFF);
  endtask

  task automatic t_nest8;
    for (int k = 0; k < 8; k++) wr(8'(13 + k), 32'(k));
    @(negedge clk); irq_src[20:13] = 8'hFF;
    for (int k = 0; k < 8; k++) begin
      wr(A_EN, 32'h1 << (13 + k));
      rd_chk("R10 nest level", A_IVR, 32'h100 + 13 + k);
    end
    chk("R10 full stack idle", {31'd0, irq_n}, 32'd1);
    rd_chk("R9 spurious when full", A_IVR, SPUR);
    wr(A_DIS, 32'h001F_C000);
    for (int k = 0; k < 7; k++) wr(A_EOI, 0);
    chk("R10 prio0 below top", {31'd0, irq_n}, 32'd1);
    wr(A_EOI, 0);
    chk("R11 eight pops idle", {31'd0, irq_n}, 32'd0);
    wr(A_EOI, 0);
    rd_chk("R11 extra pop harmless", A_IVR, 32'h10D);
    wr(A_EOI, 0);
    @(negedge clk); irq_src = '0;
    wr(A_DIS, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_config;
    t_illegal;
    t_mask;
    t_level;
    t_edge;
    t_prio;
    t_nest8;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule